// File: doc/BRIEF.md
# Next-PC and Control Transfer Unit

This block picks the program counter that follows each instruction of a 16-bit machine. It takes one instruction at a time, with the address of that instruction and the current N/Z/P condition flags. It then produces the address to run next. It handles these cases:

- plain fall-through to the next word;
- the conditional branch, tested against the flags;
- the jump through a register, and the return, which is that jump with R7 as base;
- the subroutine call, in a PC-relative form and a register form;
- the trap call, whose target is read from a vector table in memory.

The block has a read address for one register-file port and sees that register's contents in the same cycle. It drives a simple request/ready read port for the vector table. Calls and traps produce a write to the link register R7.

For every instruction except a trap, the result appears one cycle after the instruction is accepted. A trap holds the unit busy. It drives the table read until memory signals ready, and reports its result one cycle after that. When the vector that stops the program completes, a sticky halted flag is raised.

Top module: `npc_unit`

## Requirements
- R1: After reset, out_valid, link_we, mem_req, busy and halted are all 0.
- R2: An accepted instruction that is not a control transfer gives next_pc = pc+1 with link_we = 0. Control transfers use opcode (instr[15:12]) 0000, 0100, 1100 or 1111. The result appears with out_valid one cycle after the accept.
- R3: A branch is opcode 0000, with mask instr[11:9] and offset instr[8:0]. The mask bits align with cc, where bit 2 is N, bit 1 is Z and bit 0 is P. The branch is taken when (mask & cc) is nonzero, and then next_pc = pc+1+sign-extended offset.
- R4: A branch that is not taken gives pc+1. Mask 000 never branches, and mask 111 branches with any valid flag set. Word 0FFA at address 3009 goes to 3004.
- R5: Opcode 1100 loads next_pc with the register named by instr[8:6], placed on rf_raddr. It writes no link. With instr[8:6] = 7 this is the return.
- R6: Opcode 0100 with instr[11] = 1 gives next_pc = pc+1+sign-extended instr[10:0]. It writes pc+1 to R7 (link_we = 1, link_addr = 7) in the same cycle as out_valid.
- R7: Opcode 0100 with instr[11] = 0 gives next_pc = contents of the register named by instr[8:6] and links pc+1 to R7. When the base register is R7, its value from before the link write is used.
- R8: Opcode 1111 is a trap. In the cycle after the accept, mem_req = 1 and busy = 1, with mem_addr = instr[7:0] zero-extended. Both are held stable until mem_ready. One cycle after mem_ready, out_valid = 1 with next_pc = mem_rdata and an R7 link of pc+1.
- R9: Completion of trap vector 25 (hex) sets halted, which stays set until reset. Other vectors leave it clear.
- R10: While busy, instr_valid is ignored. It produces no out_valid and does not disturb the pending table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| instr_valid | input | 1 | instruction offered this cycle |
| instr | input | 16 | instruction word |
| pc | input | 16 | address of the instruction |
| cc | input | 3 | condition flags N,Z,P |
| rf_raddr | output | 3 | register-file read address |
| rf_rdata | input | 16 | register-file read data |
| mem_req | output | 1 | vector-table read request |
| mem_addr | output | 16 | vector-table address |
| mem_ready | input | 1 | table word available |
| mem_rdata | input | 16 | table word |
| busy | output | 1 | trap lookup pending |
| out_valid | output | 1 | next_pc is valid |
| next_pc | output | 16 | following program counter |
| link_we | output | 1 | link register write |
| link_addr | output | 3 | link register index (7) |
| link_data | output | 16 | link value |
| halted | output | 1 | halt vector completed |

## Verification
The bench builds the unit with its default parameters:

- a 16-bit address;
- a table base of zero, which selects the zero-extended vector address;
- 25 (hex) as the halt vector.

These values let the bench check exact hex results. They include the loop-back branch from 3009 to 3004, a trap address equal to the raw vector, and the halted flag rising on a real halt. A return to R7 and a register call through R7 are both run against a small register-file model in the bench. This shows that the old link value is the one used. Trap reads are run with several cycles of wait and with no wait. During a wait, an instruction is offered to show that it is refused.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int ILEN = 16;
   localparam int CCW  = 3;
   localparam logic [3:0] OP_BR   = 4'b0000;
   localparam logic [3:0] OP_CALL = 4'b0100;
   localparam logic [3:0] OP_JUMP = 4'b1100;
   localparam logic [3:0] OP_TRAP = 4'b1111;

   typedef enum logic [2:0] {
      K_SEQ, K_BR, K_JUMP, K_CALL_REL, K_CALL_REG, K_TRAP
   } npc_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int XLEN  = 16,
   parameter int VEC_W = 8
) (
   input  logic [ILEN-1:0]  instr,
   output npc_kind_e        kind,
   output logic [CCW-1:0]   mask,
   output logic [2:0]       base_sel,
   output logic [XLEN-1:0]  off_br,
   output logic [XLEN-1:0]  off_call,
   output logic [VEC_W-1:0] vec
);
   localparam int BR_OFFW   = 9;
   localparam int CALL_OFFW = 11;

   assign mask     = instr[11:9];
   assign base_sel = instr[8:6];
   assign vec      = instr[VEC_W-1:0];
   assign off_br   = {{(XLEN-BR_OFFW){instr[BR_OFFW-1]}}, instr[BR_OFFW-1:0]};
   assign off_call = {{(XLEN-CALL_OFFW){instr[CALL_OFFW-1]}}, instr[CALL_OFFW-1:0]};

   always_comb begin
      case (instr[15:12])
         OP_BR:   kind = K_BR;
         OP_JUMP: kind = K_JUMP;
         OP_CALL: kind = instr[11] ? K_CALL_REL : K_CALL_REG;
         OP_TRAP: kind = K_TRAP;
         default: kind = K_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN = 16
) (
   input  npc_kind_e       kind,
   input  logic [XLEN-1:0] pc_inc,
   input  logic [XLEN-1:0] off_br,
   input  logic [XLEN-1:0] off_call,
   input  logic [CCW-1:0]  mask,
   input  logic [CCW-1:0]  cc,
   input  logic [XLEN-1:0] base_val,
   output logic [XLEN-1:0] target,
   output logic            is_call
);
   logic [CCW-1:0] hit;
   logic           taken;

   for (genvar i = 0; i < CCW; i++) begin : g_cc
      assign hit[i] = mask[i] & cc[i];
   end
   assign taken = |hit;

   always_comb begin
      target  = pc_inc;
      is_call = 1'b0;
      case (kind)
         K_BR:       if (taken) target = pc_inc + off_br;
         K_JUMP:     target = base_val;
         K_CALL_REL: begin target = pc_inc + off_call; is_call = 1'b1; end
         K_CALL_REG: begin target = base_val;          is_call = 1'b1; end
         default:    target = pc_inc;
      endcase
   end
endmodule

// File: rtl/npc_trap_seq.sv
module npc_trap_seq #(
   parameter int XLEN            = 16,
   parameter int VEC_W           = 8,
   parameter int unsigned TABLE_BASE = 0,
   parameter int unsigned HALT_VEC   = 'h25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] vec,
   input  logic [XLEN-1:0]  link_in,
   input  logic             mem_ready,
   output logic             busy,
   output logic             mem_req,
   output logic [XLEN-1:0]  mem_addr,
   output logic             done,
   output logic [XLEN-1:0]  done_link,
   output logic             done_halt
);
   typedef enum logic {S_IDLE, S_WAIT} seq_e;
   seq_e             state;
   logic [VEC_W-1:0] vec_q;
   logic [XLEN-1:0]  addr_d;

   if (TABLE_BASE == 0) begin : g_zext
      assign addr_d = {{(XLEN-VEC_W){1'b0}}, vec};
   end else begin : g_based
      assign addr_d = XLEN'(TABLE_BASE) + {{(XLEN-VEC_W){1'b0}}, vec};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         vec_q     <= '0;
         mem_addr  <= '0;
         done_link <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               state     <= S_WAIT;
               vec_q     <= vec;
               mem_addr  <= addr_d;
               done_link <= link_in;
            end
            default: if (mem_ready) state <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state == S_WAIT);
   assign mem_req   = busy;
   assign done      = busy && mem_ready;
   assign done_halt = (vec_q == VEC_W'(HALT_VEC));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN                = 16,
   parameter int VEC_W               = 8,
   parameter int unsigned TABLE_BASE = 0,
   parameter int unsigned HALT_VEC   = 'h25,
   parameter int unsigned LINK_REG   = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [ILEN-1:0] instr,
   input  logic [XLEN-1:0] pc,
   input  logic [CCW-1:0]  cc,
   output logic [2:0]      rf_raddr,
   input  logic [XLEN-1:0] rf_rdata,
   output logic            mem_req,
   output logic [XLEN-1:0] mem_addr,
   input  logic            mem_ready,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            busy,
   output logic            out_valid,
   output logic [XLEN-1:0] next_pc,
   output logic            link_we,
   output logic [2:0]      link_addr,
   output logic [XLEN-1:0] link_data,
   output logic            halted
);
   initial begin
      assert (XLEN >= ILEN) else $error("XLEN must cover the instruction width");
      assert (VEC_W <= 8 && VEC_W >= 1) else $error("VEC_W out of range");
      assert (LINK_REG < 8) else $error("LINK_REG out of range");
   end

   npc_kind_e        kind;
   logic [CCW-1:0]   mask;
   logic [XLEN-1:0]  off_br, off_call, pc_inc, target;
   logic [VEC_W-1:0] vec;
   logic             is_call, accept, trap_start;
   logic             t_done, t_halt;
   logic [XLEN-1:0]  t_link;

   assign pc_inc     = pc + XLEN'(1);
   assign accept     = instr_valid && !busy;
   assign trap_start = accept && (kind == K_TRAP);
   assign link_addr  = 3'(LINK_REG);

   npc_decode #(.XLEN(XLEN), .VEC_W(VEC_W)) u_dec (
      .instr(instr), .kind(kind), .mask(mask), .base_sel(rf_raddr),
      .off_br(off_br), .off_call(off_call), .vec(vec)
   );

   npc_target #(.XLEN(XLEN)) u_tgt (
      .kind(kind), .pc_inc(pc_inc), .off_br(off_br), .off_call(off_call),
      .mask(mask), .cc(cc), .base_val(rf_rdata), .target(target), .is_call(is_call)
   );

   npc_trap_seq #(.XLEN(XLEN), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE),
                  .HALT_VEC(HALT_VEC)) u_trap (
      .clk(clk), .rst_n(rst_n), .start(trap_start), .vec(vec), .link_in(pc_inc),
      .mem_ready(mem_ready), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .done(t_done), .done_link(t_link), .done_halt(t_halt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         link_we   <= 1'b0;
         link_data <= '0;
         halted    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         link_we   <= 1'b0;
         if (t_done) begin
            out_valid <= 1'b1;
            next_pc   <= mem_rdata;
            link_we   <= 1'b1;
            link_data <= t_link;
            if (t_halt) halted <= 1'b1;
         end else if (accept && kind != K_TRAP) begin
            out_valid <= 1'b1;
            next_pc   <= target;
            link_we   <= is_call;
            link_data <= pc_inc;
         end
      end
   end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int XLEN = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [3:0]      opcode,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_ready,
   input logic [XLEN-1:0] mem_addr,
   input logic            out_valid,
   input logic            link_we,
   input logic            halted
);
   p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !busy && opcode != 4'b1111 |=> out_valid);

   p_link_with_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> out_valid);

   p_trap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

   p_trap_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> out_valid && link_we && !mem_req);

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ready |=> !out_valid);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(instr[15:12]),
   .busy(busy), .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
   .out_valid(out_valid), .link_we(link_we), .halted(halted)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
   logic        clk = 0, rst_n = 0;
   logic        instr_valid = 0;
   logic [15:0] instr = 0, pc = 0;
   logic [2:0]  cc = 0;
   logic [2:0]  rf_raddr;
   logic [15:0] rf_rdata;
   logic        mem_req, mem_ready = 0;
   logic [15:0] mem_addr, mem_rdata = 0;
   logic        busy, out_valid, link_we, halted;
   logic [15:0] next_pc, link_data;
   logic [2:0]  link_addr;

   logic [15:0] regs [8];
   logic        pre_we = 0;
   logic [2:0]  pre_idx = 0;
   logic [15:0] pre_val = 0;
   int vectors = 0, errors = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   npc_unit u_dut (.*);

   assign rf_rdata = regs[rf_raddr];
   always @(posedge clk) begin
      if (pre_we) regs[pre_idx] <= pre_val;
      else if (link_we) regs[link_addr] <= link_data;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic setreg(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk); pre_we = 1; pre_idx = idx; pre_val = val;
      @(negedge clk); pre_we = 0;
   endtask

   task automatic issue(input logic [15:0] ins, input logic [15:0] p, input logic [2:0] c);
      @(negedge clk); instr_valid = 1; instr = ins; pc = p; cc = c;
      @(negedge clk); instr_valid = 0;
   endtask

   task automatic t_reset;
      check("R1 out_valid", 16'(out_valid), 0);
      check("R1 link_we", 16'(link_we), 0);
      check("R1 mem_req", 16'(mem_req), 0);
      check("R1 busy", 16'(busy), 0);
      check("R1 halted", 16'(halted), 0);
   endtask

   task automatic t_seq;
      issue(16'h1261, 16'h3000, 3'b001);
      check("R2 valid", 16'(out_valid), 1);
      check("R2 next_pc", next_pc, 16'h3001);
      check("R2 no link", 16'(link_we), 0);
      @(negedge clk);
      check("R2 pulse", 16'(out_valid), 0);
   endtask

   task automatic t_branch;
      issue(16'h0405, 16'h3004, 3'b010);
      check("R3 z taken", next_pc, 16'h300A);
      issue(16'h0405, 16'h3004, 3'b001);
      check("R4 z not taken", next_pc, 16'h3005);
      issue(16'h09FF, 16'h5000, 3'b100);
      check("R3 n taken back", next_pc, 16'h5000);
      issue(16'h09FF, 16'h5000, 3'b011);
      check("R4 n not taken", next_pc, 16'h5001);
      issue(16'h0005, 16'h4000, 3'b111);
      check("R4 mask 000 never", next_pc, 16'h4001);
      issue(16'h0FFA, 16'h3009, 3'b001);
      check("R4 mask 111 loop", next_pc, 16'h3004);
      issue(16'h0FFA, 16'h3009, 3'b100);
      check("R4 mask 111 n", next_pc, 16'h3004);
      check("R4 no link", 16'(link_we), 0);
   endtask

   task automatic t_jump;
      setreg(3'd2, 16'hABCD);
      setreg(3'd7, 16'h1234);
      issue(16'hC080, 16'h3000, 3'b010);
      check("R5 jmp", next_pc, 16'hABCD);
      check("R5 no link", 16'(link_we), 0);
      issue(16'hC1C0, 16'h3000, 3'b010);
      check("R5 ret", next_pc, 16'h1234);
   endtask

   task automatic t_call;
      issue(16'h4810, 16'h3000, 3'b010);
      check("R6 jsr fwd", next_pc, 16'h3011);
      check("R6 link_we", 16'(link_we), 1);
      check("R6 link_addr", 16'(link_addr), 7);
      check("R6 link_data", link_data, 16'h3001);
      issue(16'h4FFF, 16'h3000, 3'b010);
      check("R6 jsr back", next_pc, 16'h3000);
      setreg(3'd7, 16'h6000);
      issue(16'h41C0, 16'h2000, 3'b010);
      check("R7 jsrr r7 target", next_pc, 16'h6000);
      check("R7 jsrr link", link_data, 16'h2001);
      check("R7 jsrr link_we", 16'(link_we), 1);
      @(negedge clk);
      check("R7 r7 updated", regs[7], 16'h2001);
   endtask

   task automatic t_trap(input logic [7:0] v, input int waits, input logic [15:0] tgt,
                         input logic [15:0] p, input bit poke, input logic exp_halt);
      issue({8'hF0, v}, p, 3'b001);
      check("R8 req", 16'(mem_req), 1);
      check("R8 busy", 16'(busy), 1);
      check("R8 addr", mem_addr, {8'h00, v});
      check("R8 no early result", 16'(out_valid), 0);
      for (int i = 0; i < waits; i++) begin
         if (poke && i == 0) begin
            instr_valid = 1; instr = 16'h1261; pc = 16'h7000;
         end
         @(negedge clk);
         instr_valid = 0;
         check("R8 held req", 16'(mem_req), 1);
         check("R8 held addr", mem_addr, {8'h00, v});
         if (poke) check("R10 ignored", 16'(out_valid), 0);
      end
      mem_ready = 1; mem_rdata = tgt;
      @(negedge clk);
      mem_ready = 0;
      check("R8 valid", 16'(out_valid), 1);
      check("R8 target", next_pc, tgt);
      check("R8 link", link_data, p + 16'd1);
      check("R8 link_we", 16'(link_we), 1);
      check("R9 halted", 16'(halted), 16'(exp_halt));
      @(negedge clk);
      check("R8 idle", 16'(busy), 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = 16'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_seq();
      t_branch();
      t_jump();
      t_call();
      t_trap(8'h23, 3, 16'h0450, 16'h3010, 1'b1, 1'b0);
      t_trap(8'h21, 0, 16'h0430, 16'h3020, 1'b0, 1'b0);
      t_trap(8'h25, 2, 16'hFD70, 16'h300A, 1'b0, 1'b1);
      issue(16'h1261, 16'h3000, 3'b001);
      check("R9 sticky", 16'(halted), 1);
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule